// File: doc/BRIEF.md
# Set-Associative Cache Miss Controller

This block is the sequencing logic of a four-way, sixty-four-set cache that keeps a four-state coherence code (Invalid, Shared, Exclusive, Modified) per line. The line data, per-way metadata and replacement order live in storage outside the block. The controller reads that storage and decides whether a processor request hits. On a miss it chooses a victim way. It pushes a dirty victim out through a writeback handshake and fetches the new line through a memory handshake. It also requests ownership before a store may modify a Shared line.

Processor requests carry a tag, set index, byte offset, write flag and a four-byte write word, and are taken only while the ready output is high. Reads complete with a one-cycle response pulse that carries the four bytes found at the offset. Lines are 64 bytes. Byte `b` of a line sits at line bits `[8b+7:8b]`, and byte `k` of a word at word bits `[8k+7:8k]`. Line addresses on the memory and writeback sides are `{tag, index}`.

Top module: `cache_miss_ctrl`

## Requirements
- R1: `cpu_rdy` is low while `rst_n` is low and whenever a lookup, writeback, fetch or ownership request is under way; it is high only in the idle state.
- R2: A request is taken in a cycle where `cpu_valid` and `cpu_rdy` are both high. In that same cycle the block raises `arr_rd_valid` and `lru_rd_valid` with the request index. The storage returns all four ways and the replacement entry in the next cycle.
- R3: A way hits when its state field is not Invalid and its stored tag equals the request tag. A read hit returns the addressed word on `cpu_rsp_data` with a one-cycle `cpu_rsp_valid` and issues no memory request.
- R4: On a miss the block raises `mem_valid` with `mem_upgrade`=0 and `mem_addr`={tag,index}, and holds both until `mem_done` pulses. A `mem_resp` of 2 installs the line as Exclusive (code 2); any other response installs it as Shared (code 1).
- R5: The victim is the lowest-numbered Invalid way. If no way is Invalid, the victim is the way named in replacement-entry bits [1:0].
- R6: A Modified victim (code 3) raises `wb_valid` with `wb_addr`={victim tag,index} and the victim line on `wb_data`, held until `wb_done` pulses, before the fetch starts.
- R7: A Shared or Exclusive victim is replaced with no writeback.
- R8: A store that hits a Shared line raises `mem_valid` with `mem_upgrade`=1 and holds it until `mem_done`. The line is then written with the store merged in and the state set to Modified.
- R9: A store that hits an Exclusive or Modified line writes the four bytes at offset, offset+1, offset+2 and offset+3 into the line and sets the state to Modified, with no memory request.
- R10: The 8-bit replacement entry holds four 2-bit way numbers, with slot k in bits [2k+1:2k] and slot 0 the least recent. Every completed access rewrites it for the same index: the accessed way goes into slot 3 and the other ways keep their relative order.
- R11: A store that misses fetches the line, merges the store into it and installs it as Modified.
- R12: `arr_wr_mask` has at most one bit set. Metadata words put the state in bits [21:20] and the tag in bits [19:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_valid | input | 1 | Processor request present |
| cpu_rdy | output | 1 | Controller can take a request |
| cpu_we | input | 1 | Request is a store |
| cpu_tag | input | 20 | Request tag |
| cpu_idx | input | 6 | Request set index |
| cpu_off | input | 6 | Request byte offset in the line |
| cpu_wdata | input | 32 | Store word |
| cpu_rsp_valid | output | 1 | Read response pulse |
| cpu_rsp_data | output | 32 | Read response word |
| arr_rd_valid | output | 1 | Storage read request |
| arr_rd_idx | output | 6 | Storage read index |
| arr_rd_data | input | 2048 | Lines of all ways, way w at [512w+511:512w] |
| arr_rd_meta | input | 88 | Metadata of all ways, way w at [22w+21:22w] |
| arr_wr_mask | output | 4 | Per-way write enable |
| arr_wr_idx | output | 6 | Storage write index |
| arr_wr_data | output | 512 | Line to write |
| arr_wr_meta | output | 22 | Metadata to write |
| lru_rd_valid | output | 1 | Replacement entry read request |
| lru_rd_idx | output | 6 | Replacement entry read index |
| lru_rd_data | input | 8 | Replacement entry returned |
| lru_wr_valid | output | 1 | Replacement entry write |
| lru_wr_idx | output | 6 | Replacement entry write index |
| lru_wr_data | output | 8 | Replacement entry to write |
| wb_valid | output | 1 | Writeback request |
| wb_addr | output | 26 | Writeback line address |
| wb_data | output | 512 | Writeback line |
| wb_done | input | 1 | Writeback complete pulse |
| mem_valid | output | 1 | Memory request |
| mem_upgrade | output | 1 | Request is an ownership upgrade |
| mem_addr | output | 26 | Memory line address |
| mem_resp | input | 2 | Response code, valid with done |
| mem_fill_data | input | 512 | Fetched line, valid with done |
| mem_done | input | 1 | Memory complete pulse |

## Verification
The assertions assume that the storage answers a read in exactly the next cycle. They also assume that `mem_done` and `wb_done` pulse only while the matching request is raised, and that the replacement entry of an accessed set is a permutation of the four way numbers. The stimulus meets these assumptions with a storage model that registers its read outputs on the clock edge, and with responders that pulse done once, two cycles after they see a request. It also seeds every replacement entry with the order 0,1,2,3 and keeps byte offsets at 60 or below, so a word never crosses the end of a line.

// File: rtl/cmc_pkg.sv
package cmc_pkg;

    typedef enum logic [1:0] {
        LINE_INV = 2'd0,
        LINE_SHR = 2'd1,
        LINE_EXC = 2'd2,
        LINE_MOD = 2'd3
    } line_state_e;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_LOOK  = 3'd1,
        ST_WB    = 3'd2,
        ST_FETCH = 3'd3,
        ST_UPG   = 3'd4
    } ctrl_state_e;

    localparam logic [1:0] RESP_OWNED = 2'd2;

endpackage

// File: rtl/cmc_way_match.sv
module cmc_way_match
    import cmc_pkg::*;
#(
    parameter int WAYS  = 4,
    parameter int TAG_W = 20,
    localparam int WAY_W  = $clog2(WAYS),
    localparam int META_W = TAG_W + 2
) (
    input  logic [WAYS*META_W-1:0] meta_i,
    input  logic [TAG_W-1:0]       tag_i,
    input  logic [WAY_W-1:0]       lru_way_i,
    output logic                   hit_o,
    output logic [WAY_W-1:0]       hit_way_o,
    output line_state_e            hit_state_o,
    output logic [WAY_W-1:0]       vic_way_o,
    output line_state_e            vic_state_o,
    output logic [TAG_W-1:0]       vic_tag_o
);

    logic [WAYS-1:0]  match_w;
    logic [WAYS-1:0]  empty_w;
    line_state_e      state_w [WAYS];
    logic [TAG_W-1:0] tag_w   [WAYS];

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        assign state_w[w] = line_state_e'(meta_i[w*META_W+TAG_W +: 2]);
        assign tag_w[w]   = meta_i[w*META_W +: TAG_W];
        assign match_w[w] = (state_w[w] != LINE_INV) && (tag_w[w] == tag_i);
        assign empty_w[w] = (state_w[w] == LINE_INV);
    end

    always_comb begin
        hit_o     = |match_w;
        hit_way_o = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (match_w[w]) hit_way_o = WAY_W'(w);
        end
        vic_way_o = lru_way_i;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (empty_w[w]) vic_way_o = WAY_W'(w);
        end
    end

    assign hit_state_o = state_w[hit_way_o];
    assign vic_state_o = state_w[vic_way_o];
    assign vic_tag_o   = tag_w[vic_way_o];

endmodule

// File: rtl/cmc_lru_touch.sv
module cmc_lru_touch #(
    parameter int WAYS = 4,
    localparam int WAY_W = $clog2(WAYS),
    localparam int LRU_W = WAYS * WAY_W
) (
    input  logic [LRU_W-1:0] order_i,
    input  logic [WAY_W-1:0] way_i,
    output logic [LRU_W-1:0] order_o
);

    logic [WAY_W-1:0] slot [WAYS];

    for (genvar s = 0; s < WAYS; s++) begin : g_slot
        assign slot[s] = order_i[s*WAY_W +: WAY_W];
    end

    always_comb begin
        int pos;
        pos     = 0;
        order_o = '0;
        for (int s = 0; s < WAYS; s++) begin
            if (slot[s] != way_i && pos < WAYS - 1) begin
                order_o[pos*WAY_W +: WAY_W] = slot[s];
                pos = pos + 1;
            end
        end
        order_o[(WAYS-1)*WAY_W +: WAY_W] = way_i;
    end

endmodule

// File: rtl/cmc_line_merge.sv
module cmc_line_merge #(
    parameter int LINE_BYTES = 64,
    parameter int WORD_BYTES = 4,
    localparam int OFF_W  = $clog2(LINE_BYTES),
    localparam int LINE_W = LINE_BYTES * 8,
    localparam int WORD_W = WORD_BYTES * 8
) (
    input  logic [LINE_W-1:0] line_i,
    input  logic [OFF_W-1:0]  off_i,
    input  logic [WORD_W-1:0] wdata_i,
    output logic [LINE_W-1:0] merged_o,
    output logic [WORD_W-1:0] word_o
);

    logic [OFF_W:0] pos [WORD_BYTES];

    for (genvar k = 0; k < WORD_BYTES; k++) begin : g_byte
        assign pos[k] = {1'b0, off_i} + (OFF_W+1)'(k);
        assign word_o[k*8 +: 8] = (pos[k] < (OFF_W+1)'(LINE_BYTES)) ?
                                  line_i[pos[k][OFF_W-1:0]*8 +: 8] : 8'h00;
    end

    always_comb begin
        merged_o = line_i;
        for (int k = 0; k < WORD_BYTES; k++) begin
            if (pos[k] < (OFF_W+1)'(LINE_BYTES)) begin
                merged_o[pos[k][OFF_W-1:0]*8 +: 8] = wdata_i[k*8 +: 8];
            end
        end
    end

endmodule

// File: rtl/cache_miss_ctrl.sv
module cache_miss_ctrl
    import cmc_pkg::*;
#(
    parameter int WAYS       = 4,
    parameter int SETS       = 64,
    parameter int TAG_W      = 20,
    parameter int LINE_BYTES = 64,
    parameter int WORD_BYTES = 4,
    localparam int WAY_W  = $clog2(WAYS),
    localparam int IDX_W  = $clog2(SETS),
    localparam int OFF_W  = $clog2(LINE_BYTES),
    localparam int LINE_W = LINE_BYTES * 8,
    localparam int WORD_W = WORD_BYTES * 8,
    localparam int META_W = TAG_W + 2,
    localparam int LRU_W  = WAYS * WAY_W,
    localparam int ADDR_W = TAG_W + IDX_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cpu_valid,
    output logic                   cpu_rdy,
    input  logic                   cpu_we,
    input  logic [TAG_W-1:0]       cpu_tag,
    input  logic [IDX_W-1:0]       cpu_idx,
    input  logic [OFF_W-1:0]       cpu_off,
    input  logic [WORD_W-1:0]      cpu_wdata,
    output logic                   cpu_rsp_valid,
    output logic [WORD_W-1:0]      cpu_rsp_data,
    output logic                   arr_rd_valid,
    output logic [IDX_W-1:0]       arr_rd_idx,
    input  logic [WAYS*LINE_W-1:0] arr_rd_data,
    input  logic [WAYS*META_W-1:0] arr_rd_meta,
    output logic [WAYS-1:0]        arr_wr_mask,
    output logic [IDX_W-1:0]       arr_wr_idx,
    output logic [LINE_W-1:0]      arr_wr_data,
    output logic [META_W-1:0]      arr_wr_meta,
    output logic                   lru_rd_valid,
    output logic [IDX_W-1:0]       lru_rd_idx,
    input  logic [LRU_W-1:0]       lru_rd_data,
    output logic                   lru_wr_valid,
    output logic [IDX_W-1:0]       lru_wr_idx,
    output logic [LRU_W-1:0]       lru_wr_data,
    output logic                   wb_valid,
    output logic [ADDR_W-1:0]      wb_addr,
    output logic [LINE_W-1:0]      wb_data,
    input  logic                   wb_done,
    output logic                   mem_valid,
    output logic                   mem_upgrade,
    output logic [ADDR_W-1:0]      mem_addr,
    input  logic [1:0]             mem_resp,
    input  logic [LINE_W-1:0]      mem_fill_data,
    input  logic                   mem_done
);

    typedef struct packed {
        ctrl_state_e       st;
        logic              we;
        logic [TAG_W-1:0]  tag;
        logic [IDX_W-1:0]  idx;
        logic [OFF_W-1:0]  off;
        logic [WORD_W-1:0] wdata;
        logic [WAY_W-1:0]  way;
        logic [TAG_W-1:0]  vtag;
        logic [LINE_W-1:0] line;
        logic [LRU_W-1:0]  lru;
        logic              rvalid;
        logic [WORD_W-1:0] rdata;
    } ctrl_regs_t;

    ctrl_regs_t r_q, r_d;

    // lookup results
    logic              hit;
    logic [WAY_W-1:0]  hit_way, vic_way;
    line_state_e       hit_state, vic_state;
    logic [TAG_W-1:0]  vic_tag;
    logic [LINE_W-1:0] hit_line, vic_line;

    // shared merge and replacement datapath
    logic [LINE_W-1:0] mrg_src, mrg_line;
    logic [WORD_W-1:0] mrg_word;
    logic [LRU_W-1:0]  lru_src, lru_new;
    logic [WAY_W-1:0]  touch_way;

    cmc_way_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_match (
        .meta_i      (arr_rd_meta),
        .tag_i       (r_q.tag),
        .lru_way_i   (lru_rd_data[WAY_W-1:0]),
        .hit_o       (hit),
        .hit_way_o   (hit_way),
        .hit_state_o (hit_state),
        .vic_way_o   (vic_way),
        .vic_state_o (vic_state),
        .vic_tag_o   (vic_tag)
    );

    cmc_lru_touch #(.WAYS(WAYS)) u_touch (
        .order_i (lru_src),
        .way_i   (touch_way),
        .order_o (lru_new)
    );

    cmc_line_merge #(.LINE_BYTES(LINE_BYTES), .WORD_BYTES(WORD_BYTES)) u_merge (
        .line_i   (mrg_src),
        .off_i    (r_q.off),
        .wdata_i  (r_q.wdata),
        .merged_o (mrg_line),
        .word_o   (mrg_word)
    );

    assign hit_line = arr_rd_data[hit_way*LINE_W +: LINE_W];
    assign vic_line = arr_rd_data[vic_way*LINE_W +: LINE_W];

    // edge-facing outputs driven from registered state
    assign cpu_rdy       = rst_n && (r_q.st == ST_IDLE);
    assign arr_rd_valid  = cpu_valid && cpu_rdy;
    assign arr_rd_idx    = cpu_idx;
    assign lru_rd_valid  = cpu_valid && cpu_rdy;
    assign lru_rd_idx    = cpu_idx;
    assign wb_valid      = (r_q.st == ST_WB);
    assign wb_addr       = {r_q.vtag, r_q.idx};
    assign wb_data       = r_q.line;
    assign mem_valid     = (r_q.st == ST_FETCH) || (r_q.st == ST_UPG);
    assign mem_upgrade   = (r_q.st == ST_UPG);
    assign mem_addr      = {r_q.tag, r_q.idx};
    assign cpu_rsp_valid = r_q.rvalid;
    assign cpu_rsp_data  = r_q.rdata;
    assign arr_wr_idx    = r_q.idx;
    assign lru_wr_idx    = r_q.idx;
    assign lru_wr_data   = lru_new;

    always_comb begin
        r_d          = r_q;
        r_d.rvalid   = 1'b0;
        arr_wr_mask  = '0;
        arr_wr_data  = mrg_line;
        arr_wr_meta  = {LINE_MOD, r_q.tag};
        lru_wr_valid = 1'b0;
        mrg_src      = r_q.line;
        lru_src      = r_q.lru;
        touch_way    = r_q.way;

        unique case (r_q.st)
            ST_IDLE: begin
                if (cpu_valid && cpu_rdy) begin
                    r_d.st    = ST_LOOK;
                    r_d.we    = cpu_we;
                    r_d.tag   = cpu_tag;
                    r_d.idx   = cpu_idx;
                    r_d.off   = cpu_off;
                    r_d.wdata = cpu_wdata;
                end
            end
            ST_LOOK: begin
                mrg_src   = hit_line;
                lru_src   = lru_rd_data;
                touch_way = hit_way;
                r_d.lru   = lru_rd_data;
                if (hit) begin
                    if (!r_q.we) begin
                        r_d.rvalid   = 1'b1;
                        r_d.rdata    = mrg_word;
                        lru_wr_valid = 1'b1;
                        r_d.st       = ST_IDLE;
                    end else if (hit_state == LINE_SHR) begin
                        r_d.way  = hit_way;
                        r_d.line = hit_line;
                        r_d.st   = ST_UPG;
                    end else begin
                        arr_wr_mask  = WAYS'(1) << hit_way;
                        lru_wr_valid = 1'b1;
                        r_d.st       = ST_IDLE;
                    end
                end else begin
                    r_d.way  = vic_way;
                    r_d.vtag = vic_tag;
                    r_d.line = vic_line;
                    r_d.st   = (vic_state == LINE_MOD) ? ST_WB : ST_FETCH;
                end
            end
            ST_WB: begin
                if (wb_done) r_d.st = ST_FETCH;
            end
            ST_FETCH: begin
                mrg_src = mem_fill_data;
                if (mem_done) begin
                    arr_wr_mask  = WAYS'(1) << r_q.way;
                    lru_wr_valid = 1'b1;
                    r_d.st       = ST_IDLE;
                    if (r_q.we) begin
                        arr_wr_meta = {LINE_MOD, r_q.tag};
                    end else begin
                        arr_wr_data = mem_fill_data;
                        arr_wr_meta = {(mem_resp == RESP_OWNED) ? LINE_EXC : LINE_SHR,
                                       r_q.tag};
                        r_d.rvalid  = 1'b1;
                        r_d.rdata   = mrg_word;
                    end
                end
            end
            ST_UPG: begin
                if (mem_done) begin
                    arr_wr_mask  = WAYS'(1) << r_q.way;
                    lru_wr_valid = 1'b1;
                    r_d.st       = ST_IDLE;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    // R1: any outstanding handshake implies not ready
    a_r1_busy_blocks_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid || wb_valid) |-> !cpu_rdy);

    // R2: an accepted request reads both storages at once
    a_r2_accept_reads: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_valid && cpu_rdy) |-> (arr_rd_valid && lru_rd_valid && lru_rd_idx == arr_rd_idx));

    // R4: memory request held steady until done
    a_r4_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_done) |=> (mem_valid && $stable(mem_addr) && $stable(mem_upgrade)));

    // R6: writeback held steady until done, never alongside a memory request
    a_r6_wb_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_valid && !wb_done) |=> (wb_valid && $stable(wb_addr)));
    a_r6_wb_then_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_valid && wb_done) |=> (mem_valid && !mem_upgrade));

    // R8: completed upgrade writes a Modified line
    a_r8_upgrade_mod: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && mem_upgrade && mem_done) |->
        (arr_wr_mask != '0 && arr_wr_meta[TAG_W +: 2] == LINE_MOD));

    // R9: a write that needs no memory traffic marks the line Modified
    a_r9_hit_write_mod: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_wr_mask != '0 && !mem_valid) |-> (arr_wr_meta[TAG_W +: 2] == LINE_MOD));

    // R10: every storage write comes with a replacement update
    a_r10_lru_with_write: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_wr_mask != '0) |-> lru_wr_valid);

    // R12: at most one way written per cycle
    a_r12_one_way: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(arr_wr_mask));

endmodule

// File: tb/cache_miss_ctrl_tb_top.sv
`timescale 1ns/1ps
module cache_miss_ctrl_tb_top;

    localparam int W  = 4;
    localparam int S  = 64;
    localparam int LW = 512;
    localparam int MW = 22;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic          cpu_valid = 1'b0, cpu_rdy, cpu_we = 1'b0;
    logic [19:0]   cpu_tag = '0;
    logic [5:0]    cpu_idx = '0, cpu_off = '0;
    logic [31:0]   cpu_wdata = '0;
    logic          cpu_rsp_valid;
    logic [31:0]   cpu_rsp_data;
    logic          arr_rd_valid;
    logic [5:0]    arr_rd_idx, arr_wr_idx, lru_rd_idx, lru_wr_idx;
    logic [W*LW-1:0] arr_rd_data = '0;
    logic [W*MW-1:0] arr_rd_meta = '0;
    logic [3:0]    arr_wr_mask;
    logic [LW-1:0] arr_wr_data, wb_data;
    logic [MW-1:0] arr_wr_meta;
    logic          lru_rd_valid, lru_wr_valid;
    logic [7:0]    lru_rd_data = '0, lru_wr_data;
    logic          wb_valid, wb_done = 1'b0;
    logic [25:0]   wb_addr, mem_addr;
    logic          mem_valid, mem_upgrade, mem_done = 1'b0;
    logic [1:0]    mem_resp = '0;
    logic [LW-1:0] mem_fill_data = '0;

    cache_miss_ctrl dut_i (
        .clk(clk), .rst_n(rst_n),
        .cpu_valid(cpu_valid), .cpu_rdy(cpu_rdy), .cpu_we(cpu_we),
        .cpu_tag(cpu_tag), .cpu_idx(cpu_idx), .cpu_off(cpu_off), .cpu_wdata(cpu_wdata),
        .cpu_rsp_valid(cpu_rsp_valid), .cpu_rsp_data(cpu_rsp_data),
        .arr_rd_valid(arr_rd_valid), .arr_rd_idx(arr_rd_idx),
        .arr_rd_data(arr_rd_data), .arr_rd_meta(arr_rd_meta),
        .arr_wr_mask(arr_wr_mask), .arr_wr_idx(arr_wr_idx),
        .arr_wr_data(arr_wr_data), .arr_wr_meta(arr_wr_meta),
        .lru_rd_valid(lru_rd_valid), .lru_rd_idx(lru_rd_idx), .lru_rd_data(lru_rd_data),
        .lru_wr_valid(lru_wr_valid), .lru_wr_idx(lru_wr_idx), .lru_wr_data(lru_wr_data),
        .wb_valid(wb_valid), .wb_addr(wb_addr), .wb_data(wb_data), .wb_done(wb_done),
        .mem_valid(mem_valid), .mem_upgrade(mem_upgrade), .mem_addr(mem_addr),
        .mem_resp(mem_resp), .mem_fill_data(mem_fill_data), .mem_done(mem_done)
    );

    // ---------------- external storage model ----------------
    logic [LW-1:0] dmem [W][S];
    logic [MW-1:0] mmem [W][S];
    logic [7:0]    lmem [S];

    initial begin
        for (int w = 0; w < W; w++)
            for (int s = 0; s < S; s++) begin
                dmem[w][s] = '0;
                mmem[w][s] = '0;
            end
        for (int s = 0; s < S; s++) lmem[s] = 8'hE4;
    end

    always @(posedge clk) begin
        for (int w = 0; w < W; w++) begin
            if (arr_wr_mask[w]) begin
                dmem[w][arr_wr_idx] <= arr_wr_data;
                mmem[w][arr_wr_idx] <= arr_wr_meta;
            end
            if (arr_rd_valid) begin
                arr_rd_data[w*LW +: LW] <= dmem[w][arr_rd_idx];
                arr_rd_meta[w*MW +: MW] <= mmem[w][arr_rd_idx];
            end
        end
        if (lru_wr_valid) lmem[lru_wr_idx] <= lru_wr_data;
        if (lru_rd_valid) lru_rd_data <= lmem[lru_rd_idx];
    end

    // ---------------- memory side ----------------
    logic [7:0] bmem [logic [31:0]];
    logic [7:0] refm [logic [31:0]];

    function automatic logic [7:0] dflt(input logic [31:0] a);
        return 8'(a * 37 + (a >> 7) + 32'h11);
    endfunction

    function automatic logic [7:0] mem_byte(input logic [31:0] a);
        return bmem.exists(a) ? bmem[a] : dflt(a);
    endfunction

    function automatic logic [7:0] ref_byte(input logic [31:0] a);
        return refm.exists(a) ? refm[a] : dflt(a);
    endfunction

    int        fetch_cnt = 0, upg_cnt = 0, wb_cnt = 0;
    logic [25:0] last_fetch, last_wb;
    logic [1:0]  resp_code = 2'd2;

    initial forever begin
        @(negedge clk);
        if (mem_valid) begin
            if (mem_upgrade) upg_cnt++;
            else begin
                fetch_cnt++;
                last_fetch = mem_addr;
            end
            repeat (2) @(negedge clk);
            for (int b = 0; b < 64; b++)
                mem_fill_data[b*8 +: 8] = mem_byte({mem_addr, 6'(b)});
            mem_resp = resp_code;
            mem_done = 1'b1;
            @(negedge clk);
            mem_done = 1'b0;
            mem_resp = 2'd0;
        end
    end

    initial forever begin
        @(negedge clk);
        if (wb_valid) begin
            wb_cnt++;
            last_wb = wb_addr;
            for (int b = 0; b < 64; b++) bmem[{wb_addr, 6'(b)}] = wb_data[b*8 +: 8];
            repeat (2) @(negedge clk);
            wb_done = 1'b1;
            @(negedge clk);
            wb_done = 1'b0;
        end
    end

    // ---------------- checking ----------------
    int nvec = 0, nerr = 0;
    bit done_flag = 1'b0;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        nvec++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    logic [31:0] exp_q [$];
    string       req_q [$];

    // scoreboard monitor
    initial forever begin
        @(negedge clk);
        if (rst_n && cpu_rsp_valid) begin
            if (exp_q.size() == 0) chk("R3 unexpected response", 64'(cpu_rsp_data), 64'hFFFF_FFFF_FFFF_FFFF);
            else begin
                string r;
                logic [31:0] e;
                e = exp_q.pop_front();
                r = req_q.pop_front();
                chk(r, 64'(cpu_rsp_data), 64'(e));
            end
        end
    end

    // driver
    task automatic access(input bit we, input logic [19:0] tag, input logic [5:0] idx,
                          input logic [5:0] off, input logic [31:0] wd, input string req);
        logic [31:0] e;
        while (!cpu_rdy) @(negedge clk);
        cpu_valid = 1'b1; cpu_we = we; cpu_tag = tag; cpu_idx = idx;
        cpu_off = off; cpu_wdata = wd;
        for (int k = 0; k < 4; k++) begin
            logic [31:0] a;
            a = {tag, idx, 6'(32'(off) + k)};
            if (we) refm[a] = wd[k*8 +: 8];
            else e[k*8 +: 8] = ref_byte(a);
        end
        if (!we) begin
            exp_q.push_back(e);
            req_q.push_back(req);
        end
        #1;
        chk("R2 read request at accept", {62'd0, arr_rd_valid, lru_rd_valid}, 64'd3);
        chk("R2 read index", 64'(arr_rd_idx), 64'(idx));
        @(negedge clk);
        cpu_valid = 1'b0;
        chk("R1 not ready after accept", 64'(cpu_rdy), 64'd0);
        while (!cpu_rdy) @(negedge clk);
        @(negedge clk);
    endtask

    localparam logic [5:0] IX = 6'd5;

    initial begin
        int fc;
        repeat (3) @(negedge clk);
        chk("R1 not ready in reset", 64'(cpu_rdy), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 ready after reset", 64'(cpu_rdy), 64'd1);

        // read miss into empty set
        resp_code = 2'd2;
        access(1'b0, 20'd1, IX, 6'd0, '0, "R4 read miss data");
        chk("R4 fetch address", 64'(last_fetch), 64'({20'd1, IX}));
        chk("R5 lowest invalid way / R4 exclusive", 64'(mmem[0][IX]), 64'({2'd2, 20'd1}));
        // read hit
        fc = fetch_cnt;
        access(1'b0, 20'd1, IX, 6'd4, '0, "R3 read hit data");
        chk("R3 no memory request on hit", 64'(fetch_cnt), 64'(fc));
        // write hit exclusive
        access(1'b1, 20'd1, IX, 6'd8, 32'hDEADBEEF, "R9");
        chk("R9 state modified", 64'(mmem[0][IX]), 64'({2'd3, 20'd1}));
        chk("R9 no memory traffic", 64'(fetch_cnt + upg_cnt), 64'(fc));
        access(1'b0, 20'd1, IX, 6'd8, '0, "R9 merged bytes");
        // fill the rest Shared
        resp_code = 2'd1;
        access(1'b0, 20'd2, IX, 6'd12, '0, "R4 shared fill data");
        access(1'b0, 20'd3, IX, 6'd16, '0, "R4 shared fill data");
        access(1'b0, 20'd4, IX, 6'd24, '0, "R4 shared fill data");
        chk("R4 shared install", 64'(mmem[3][IX]), 64'({2'd1, 20'd4}));
        // store to Shared line: upgrade
        resp_code = 2'd2;
        access(1'b1, 20'd2, IX, 6'd60, 32'h0BADF00D, "R8");
        chk("R8 upgrade request", 64'(upg_cnt), 64'd1);
        chk("R8 line modified", 64'(mmem[1][IX]), 64'({2'd3, 20'd2}));
        // evict Modified way 0
        access(1'b0, 20'd5, IX, 6'd32, '0, "R6 fill after writeback");
        chk("R6 writeback count", 64'(wb_cnt), 64'd1);
        chk("R6 writeback address", 64'(last_wb), 64'({20'd1, IX}));
        chk("R5 LRU victim way 0", 64'(mmem[0][IX]), 64'({2'd2, 20'd5}));
        // evict clean way 2
        access(1'b0, 20'd6, IX, 6'd0, '0, "R7 fill data");
        chk("R7 no writeback for clean victim", 64'(wb_cnt), 64'd1);
        chk("R5 LRU victim way 2", 64'(mmem[2][IX]), 64'({2'd2, 20'd6}));
        chk("R10 replacement order", 64'(lmem[IX]), 64'h87);
        // re-read written-back line
        access(1'b0, 20'd1, IX, 6'd8, '0, "R6 written-back data returns");
        chk("R7 clean way 3 dropped", 64'(wb_cnt), 64'd1);
        // write miss evicting Modified way 1
        access(1'b1, 20'd7, IX, 6'd20, 32'hCAFE1234, "R11");
        chk("R11 writeback of old line", 64'(last_wb), 64'({20'd2, IX}));
        chk("R11 installed modified", 64'(mmem[1][IX]), 64'({2'd3, 20'd7}));
        access(1'b0, 20'd7, IX, 6'd20, '0, "R11 merged data");
        access(1'b0, 20'd2, IX, 6'd60, '0, "R8 upgraded store survives eviction");
        chk("R12 meta layout way 0", 64'(mmem[0][IX]), 64'({2'd2, 20'd2}));
        chk("R4 total fetches", 64'(fetch_cnt), 64'd9);
        repeat (4) @(negedge clk);
        chk("R3 all responses seen", 64'(exp_q.size()), 64'd0);
        done_flag = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done_flag) begin
            nvec++;
            nerr++;
            $display("FAIL watchdog R1 actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
            $finish;
        end
    end

endmodule